// File: doc/BRIEF.md
# Per-Core Interval Tick Timer

This block is a single local event timer for one processor core. A prescaler divides the input clock into ticks, and a down-counting event counter, advanced once per tick, raises an interrupt flag when it runs out. Software picks between interval operation, where the counter reloads from its buffer and fires again and again, and one-shot operation, where the counter stays at zero after the first event until software reprograms or stops it.

Software reaches the timer through a small word-wide register file. The prescale value, the event count buffer and the control word are buffered: a write to any of them takes effect a fixed number of cycles after the bus write. A separate write-status register records the completion of each buffered write so that software can poll it. The interrupt status is write-1-to-clear, and an enable bit gates it onto the interrupt output.

Register indices (on `wr_addr` and `rd_addr`): 0 prescale value, 1 event count buffer, 2 control, 3 interrupt status, 4 interrupt enable, 5 write status, 6 live event count (read-only).

Top module: `core_tick_timer`

## Requirements
- R1: While control bit 0 is set, a tick occurs every (prescale value + 1) clock cycles. The first tick comes prescale + 1 cycles after the control write takes effect.
- R2: A write to index 1 with bit 31 set loads bits 30:0 into both the count buffer and the live event count.
- R3: A write to index 1 with bit 31 clear updates the count buffer only. The live event count keeps its value.
- R4: With control bits 1 and 2 set, the tick that takes the live count from 1 to 0 sets interrupt status bit 0. In the same cycle the live count reloads from the buffer, so events repeat every (buffer × (prescale + 1)) cycles.
- R5: With control bit 2 clear (one-shot), the live count stays at 0 after an event and no further event occurs while the timer keeps running.
- R6: Clearing control bits 0 and 1 stops the ticks. The live count then holds its value.
- R7: Interrupt status bit 0 is cleared by writing 1 to it. Writing 0 leaves it unchanged. A new event in the same cycle as a clear wins.
- R8: The interrupt output equals status bit 0 gated by enable bit 0. With enable clear, an event sets the status but the output stays low.
- R9: A write to index 0, 1 or 2 becomes active exactly 2 cycles after the bus write, and in that same cycle write-status bit 0, bit 1 or bit 3 is set. Bit 2 always reads 0.
- R10: Each write-status bit is cleared by writing 1 to it at index 5. A write of 0 leaves it unchanged.
- R11: After synchronous reset every register, the live count and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register index for the combinational read |
| rd_data | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request, status gated by enable |

## Verification
Two things are hard to reach from the ports: a second interval event that comes from an automatic reload, and a one-shot counter that stays at zero while the timer keeps running. Nothing outside the block shows when ticks happen. The stimulus therefore programs small prescale and count values, and computes every event cycle from the cycle in which the control write takes effect. It clears the status between events so that each event gives a fresh rising edge on the interrupt, and it reads the live count back through index 6 at a computed cycle to confirm the reload, the hold after a stop and the zero after a one-shot event.

// File: rtl/tick_timer_pkg.sv
// Shared register indices and bit positions for the per-core tick timer.
package tick_timer_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        REG_PRESCALE  = 3'd0,
        REG_COUNT_BUF = 3'd1,
        REG_CTRL      = 3'd2,
        REG_STAT      = 3'd3,
        REG_ENABLE    = 3'd4,
        REG_WSTAT     = 3'd5,
        REG_LIVE      = 3'd6
    } reg_idx_e;

    localparam int CTRL_TICK_RUN = 0;
    localparam int CTRL_CNT_RUN  = 1;
    localparam int CTRL_INTERVAL = 2;

    localparam int WS_PRESCALE = 0;
    localparam int WS_COUNT    = 1;
    localparam int WS_CTRL     = 3;

    localparam int LOAD_FLAG = 31;
endpackage

// File: rtl/tmr_wr_pipe.sv
// Delay line for buffered register writes.
// Assumes LAT >= 2. A write captured at edge E comes out valid after edge
// E+LAT-2, so the consumer applies it at edge E+LAT-1, i.e. LAT cycles after
// the bus write is presented.
module tmr_wr_pipe #(
    parameter int LAT = 2,
    parameter int AW  = 3,
    parameter int DW  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data
);
    localparam int STAGES = LAT - 1;

    logic          v_q [STAGES];
    logic [AW-1:0] a_q [STAGES];
    logic [DW-1:0] d_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the incoming write.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        v_q[0] <= 1'b0;
                        a_q[0] <= '0;
                        d_q[0] <= '0;
                    end else begin
                        v_q[0] <= in_valid;
                        a_q[0] <= in_addr;
                        d_q[0] <= in_data;
                    end
                end
            end else begin : g_next
                // Shift the write one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        v_q[s] <= 1'b0;
                        a_q[s] <= '0;
                        d_q[s] <= '0;
                    end else begin
                        v_q[s] <= v_q[s-1];
                        a_q[s] <= a_q[s-1];
                        d_q[s] <= d_q[s-1];
                    end
                end
            end
        end
    endgenerate

    assign out_valid = v_q[STAGES-1];
    assign out_addr  = a_q[STAGES-1];
    assign out_data  = d_q[STAGES-1];
endmodule

// File: rtl/tmr_prescaler.sv
// Tick prescaler: while run is high, emits a one-cycle tick every limit+1
// cycles. Assumes limit is stable while running. Stopping clears the count.
module tmr_prescaler #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          tick
);
    logic [TW-1:0] pcnt_q;

    assign tick = run && (pcnt_q == limit);

    // Count cycles up to the limit, then wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pcnt_q <= '0;
        else if (tick)      pcnt_q <= '0;
        else                pcnt_q <= pcnt_q + 1'b1;
    end
endmodule

// File: rtl/tmr_event_counter.sv
// Down-counter advanced by prescaler ticks. Flags an event on the 1->0
// step. In interval mode it reloads from the buffer; otherwise it stays at 0.
// A direct load has priority over counting.
module tmr_event_counter #(
    parameter int CW = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          interval,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] reload_val,
    output logic [CW-1:0] cnt,
    output logic          evt
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic          step;
    logic [CW-1:0] cnt_q;

    assign step = run && tick;
    assign evt  = step && (cnt_q == ONE);
    assign cnt  = cnt_q;

    // Load, decrement, reload or hold the live count.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (step) begin
            if (cnt_q <= ONE)     cnt_q <= interval ? reload_val : '0;
            else                  cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/core_tick_timer.sv
// Per-core interval tick timer: register file, buffered-write pipeline,
// prescaler and event counter. Assumes a single writer; reads are
// combinational.
module core_tick_timer
    import tick_timer_pkg::*;
#(
    parameter int WR_LAT = 2,
    parameter int TICK_W = 32,
    parameter int CNT_W  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o
);
    logic [TICK_W-1:0] prescale_q;
    logic [CNT_W-1:0]  cbuf_q;
    logic [2:0]        ctrl_q;
    logic              stat_q;
    logic              en_q;
    logic [3:0]        wstat_q;

    logic              buf_wr;
    logic              ap_v;
    logic [ADDR_W-1:0] ap_a;
    logic [DATA_W-1:0] ap_d;
    logic              tick_w;
    logic              evt_w;
    logic              load_w;
    logic [CNT_W-1:0]  live_w;
    logic [3:0]        ws_set;
    logic [3:0]        ws_clr;
    logic              st_clr;

    assign buf_wr = wr_en && (wr_addr == REG_PRESCALE || wr_addr == REG_COUNT_BUF
                              || wr_addr == REG_CTRL);

    tmr_wr_pipe #(.LAT(WR_LAT), .AW(ADDR_W), .DW(DATA_W)) i_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_valid(buf_wr), .in_addr(wr_addr), .in_data(wr_data),
        .out_valid(ap_v), .out_addr(ap_a), .out_data(ap_d)
    );

    tmr_prescaler #(.TW(TICK_W)) i_presc (
        .clk(clk), .rst_n(rst_n),
        .run(ctrl_q[CTRL_TICK_RUN]), .limit(prescale_q), .tick(tick_w)
    );

    assign load_w = ap_v && (ap_a == REG_COUNT_BUF) && ap_d[LOAD_FLAG];

    tmr_event_counter #(.CW(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n),
        .run(ctrl_q[CTRL_CNT_RUN]), .interval(ctrl_q[CTRL_INTERVAL]),
        .tick(tick_w), .load(load_w), .load_val(ap_d[CNT_W-1:0]),
        .reload_val(cbuf_q), .cnt(live_w), .evt(evt_w)
    );

    // Decode write-status set and clear masks.
    always_comb begin
        ws_set = '0;
        if (ap_v) begin
            if (ap_a == REG_PRESCALE)  ws_set[WS_PRESCALE] = 1'b1;
            if (ap_a == REG_COUNT_BUF) ws_set[WS_COUNT]    = 1'b1;
            if (ap_a == REG_CTRL)      ws_set[WS_CTRL]     = 1'b1;
        end
        ws_clr = (wr_en && wr_addr == REG_WSTAT) ? wr_data[3:0] : 4'b0;
        st_clr = wr_en && (wr_addr == REG_STAT) && wr_data[0];
    end

    // Apply buffered writes when they leave the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prescale_q <= '0;
            cbuf_q     <= '0;
            ctrl_q     <= '0;
        end else if (ap_v) begin
            if (ap_a == REG_PRESCALE)  prescale_q <= ap_d[TICK_W-1:0];
            if (ap_a == REG_COUNT_BUF) cbuf_q     <= ap_d[CNT_W-1:0];
            if (ap_a == REG_CTRL)      ctrl_q     <= ap_d[2:0];
        end
    end

    // Direct registers: enable, status and write status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            stat_q  <= 1'b0;
            wstat_q <= '0;
        end else begin
            if (wr_en && wr_addr == REG_ENABLE) en_q <= wr_data[0];
            stat_q  <= (stat_q && !st_clr) || evt_w;
            wstat_q <= (wstat_q & ~ws_clr) | ws_set;
        end
    end

    assign irq_o = stat_q && en_q;

    // Combinational read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_PRESCALE:  rd_data = DATA_W'(prescale_q);
            REG_COUNT_BUF: rd_data = DATA_W'(cbuf_q);
            REG_CTRL:      rd_data = DATA_W'(ctrl_q);
            REG_STAT:      rd_data = DATA_W'(stat_q);
            REG_ENABLE:    rd_data = DATA_W'(en_q);
            REG_WSTAT:     rd_data = DATA_W'(wstat_q);
            REG_LIVE:      rd_data = DATA_W'(live_w);
            default:       rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
// Temporal checks on the tick timer, bound into core_tick_timer.
module tmr_checker
    import tick_timer_pkg::*;
#(
    parameter int TICK_W = 32,
    parameter int CNT_W  = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              evt,
    input logic [2:0]        ctrl,
    input logic [CNT_W-1:0]  live,
    input logic [CNT_W-1:0]  cbuf,
    input logic [TICK_W-1:0] prescale,
    input logic              load,
    input logic              ap_v,
    input logic [ADDR_W-1:0] ap_a,
    input logic [3:0]        wstat,
    input logic              stat
);
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && prescale != '0) |=> (!tick || prescale == '0)); // R1

    AST_INTERVAL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && ctrl[CTRL_INTERVAL] && !load) |=> (live == $past(cbuf))); // R4

    AST_ONESHOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !ctrl[CTRL_INTERVAL] && !load) |=> (live == '0)); // R5

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[CTRL_CNT_RUN] && !load) |=> $stable(live)); // R6

    AST_STAT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat) |-> $past(evt)); // R4

    AST_CTRL_WSTAT: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_v && ap_a == REG_CTRL) |=> wstat[WS_CTRL]); // R9

    AST_WSTAT_BIT2: assert property (@(posedge clk) disable iff (!rst_n)
        !wstat[2]); // R9
endmodule

bind core_tick_timer tmr_checker #(.TICK_W(TICK_W), .CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .evt(evt_w), .ctrl(ctrl_q),
    .live(live_w), .cbuf(cbuf_q), .prescale(prescale_q), .load(load_w),
    .ap_v(ap_v), .ap_a(ap_a), .wstat(wstat_q), .stat(stat_q)
);

// File: tb/test_core_tick_timer.sv
// Scoreboard bench: the driver pushes expected interrupt edges into a
// queue, and the monitor pops them as rising edges appear on irq_o.
module test_core_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int exp_q[$];
    logic irq_prev = 1'b0;
    bit done = 1'b0;

    core_tick_timer i_core_tick_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write; returns the edge number at which the write was captured.
    task automatic wr(input logic [2:0] a, input logic [31:0] d, output int cap);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        cap = cyc;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input longint exp, input string req);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: compare each irq_o rising edge with the next expected edge.
    always @(negedge clk) begin
        if (rst_n && irq_o && !irq_prev) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected irq", cyc, -1);
            end else begin
                check("R1/R4 irq edge", cyc, exp_q.pop_front());
            end
        end
        irq_prev <= irq_o;
    end

    initial begin
        int c;
        int a;
        int live;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        for (int i = 0; i < 7; i++) rd_chk(3'(i), 0, "R11 reset reg");
        check("R11 irq reset", irq_o, 0);

        // R9: prescale write becomes active 2 cycles after the write
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'd1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_chk(3'd5, 0, "R9 wstat not yet");
        rd_chk(3'd0, 0, "R9 prescale not yet");
        @(negedge clk);
        rd_chk(3'd5, 1, "R9 wstat bit0");
        rd_chk(3'd0, 1, "R1 prescale value");
        // R10: write 0 keeps, write 1 clears
        wr(3'd5, 32'h0, c);
        rd_chk(3'd5, 1, "R10 wstat w0 keeps");
        wr(3'd5, 32'h1, c);
        rd_chk(3'd5, 0, "R10 wstat w1c");

        // R3: buffer-only update
        wr(3'd1, 32'd5, c);
        @(negedge clk);
        rd_chk(3'd1, 5, "R3 buffer updated");
        rd_chk(3'd6, 0, "R3 live unchanged");
        rd_chk(3'd5, 2, "R9 wstat bit1");
        // R2: load flag
        wr(3'd1, 32'h8000_0003, c);
        @(negedge clk);
        rd_chk(3'd6, 3, "R2 live loaded");
        rd_chk(3'd1, 3, "R2 buffer loaded");
        wr(3'd5, 32'hF, c);
        wr(3'd4, 32'd1, c);

        // R4/R1: interval run, prescale 1, count 3 -> events at A+6, A+12
        wr(3'd2, 32'h7, c);
        a = c + 1;
        exp_q.push_back(a + 6);
        exp_q.push_back(a + 12);
        wait_until(a + 1);
        rd_chk(3'd5, 8, "R9 wstat bit3");
        wait_until(a + 8);
        wr(3'd3, 32'h1, c);
        wait_until(a + 13);
        rd_chk(3'd6, 3, "R4 reload after event");
        // R6: stop, live holds
        wr(3'd2, 32'h0, c);
        @(negedge clk);
        rd_addr = 3'd6; #1; live = rd_data;
        wr(3'd3, 32'h1, c);
        repeat (20) @(negedge clk);
        rd_chk(3'd6, live, "R6 live held");
        rd_chk(3'd3, 0, "R6 no event when stopped");

        // R5: one-shot, prescale 0, count 2 -> event at C+2
        wr(3'd0, 32'd0, c);
        wr(3'd1, 32'h8000_0002, c);
        wr(3'd2, 32'h3, c);
        a = c + 1;
        exp_q.push_back(a + 2);
        wait_until(a + 4);
        rd_chk(3'd6, 0, "R5 live zero");
        wr(3'd3, 32'h1, c);
        repeat (10) @(negedge clk);
        rd_chk(3'd3, 0, "R5 no re-fire");
        rd_chk(3'd6, 0, "R5 stays zero");
        check("R5 irq low", irq_o, 0);

        // R8: enable off, event sets status only
        wr(3'd4, 32'd0, c);
        wr(3'd1, 32'h8000_0002, c);
        a = c + 1;
        wait_until(a + 3);
        rd_chk(3'd3, 1, "R8 status set");
        check("R8 irq gated", irq_o, 0);
        // R7: write 0 keeps, write 1 clears
        wr(3'd3, 32'h0, c);
        rd_chk(3'd3, 1, "R7 w0 keeps");
        wr(3'd3, 32'h1, c);
        rd_chk(3'd3, 0, "R7 w1c");

        repeat (3) @(negedge clk);
        check("R4 all expected edges seen", exp_q.size(), 0);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int n;
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (!done) check("watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule